// File: doc/BRIEF.md
# PCI Type-0 Configuration Address Translator

This block sits between a CPU-side configuration window and a PCI configuration bus port. A CPU access into the window arrives as a 32-bit offset, a byte count, a write flag and write data. A separate mapping register value supplies the upper half of the configuration address. The block joins the two halves into one 32-bit address. The one-hot IDSEL field in that address selects the device. The block then emits a type-0 configuration cycle address that carries the bus number, device, function, register and byte lane, with the enable bit set.

If the mapping register selects a type-1 cycle, the byte count is not supported, or no IDSEL bit is set, the access is not forwarded. A dropped write vanishes. A dropped read returns all ones. An empty IDSEL field also leaves a sticky error flag. A forwarded read waits for the downstream port to return data, then answers the CPU side one cycle later.

The block also keeps the bridge's two received-abort status bits. Other logic sets them through pulses. Every accepted access clears both bits.

Top module: `cfg_addr_xlate`

## Requirements
- R1: A forwarded access raises `cfg_valid` for exactly one cycle, in the cycle after acceptance. In that cycle `cfg_addr` bit 31 is 1 and bits 30:24 are 0. Bits 10:8 carry function bits 10:8 of the joined address {map_reg[15:0], req_offset[15:0]}. Bits 7:2 carry register bits 7:2 of that address, and bits 1:0 carry offset bits 1:0. `cfg_write`, `cfg_wdata` and `cfg_size` repeat the request's values.
- R2: `cfg_addr` bits 15:11 hold the index, from 0 to 20, of the lowest set bit among bits 31:11 of the joined address. Joined bit 11 gives device 0 and joined bit 31 gives device 20.
- R3: When map_reg bit 16 is 1, nothing is forwarded. A read then answers with `resp_valid` in the cycle after acceptance. Its data is 0xFF for size 1, 0xFFFF for size 2 and 0xFFFFFFFF for size 4.
- R4: When map_reg bit 16 is 0, the size is legal and joined bits 31:11 are all zero, nothing is forwarded and `err_flag` becomes 1. The flag stays 1 until reset. A read answers with all ones for its width in the cycle after acceptance.
- R5: `req_size` gives the byte count, and only 1, 2 and 4 are forwarded. Any other value is dropped without setting `err_flag`. A read with such a size answers 0xFFFFFFFF in the cycle after acceptance.
- R6: After a read is forwarded, `req_ready` stays 0 until `cfg_rvalid` is seen. `resp_valid` then pulses for one cycle in the next cycle. Its data is `cfg_rdata` with every byte above the access width forced to zero. A `cfg_rvalid` with no read outstanding is ignored.
- R7: `mabort_set` and `tabort_set` each set a sticky status bit. Any accepted access clears both bits in the following cycle, and this clear wins over a set pulse in the same cycle.
- R8: `cfg_addr` bits 23:16 hold `bus_num` as sampled at acceptance.
- R9: After reset, `req_ready` is 1 and `cfg_valid`, `resp_valid`, `err_flag` and both status bits are 0.
- R10: A write, whether forwarded or dropped, never produces `resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU access request |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_offset | input | 32 | Offset within the configuration window |
| req_size | input | 3 | Access byte count (1, 2 or 4) |
| req_wdata | input | 32 | Write data |
| map_reg | input | 32 | Mapping register value; bits 15:0 high address, bit 16 type-1 select |
| bus_num | input | 8 | Bus number placed in the cycle address |
| cfg_valid | output | 1 | Configuration cycle issue pulse |
| cfg_write | output | 1 | Configuration cycle direction |
| cfg_addr | output | 32 | Type-0 configuration address with enable bit |
| cfg_size | output | 3 | Configuration cycle byte count |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rvalid | input | 1 | Downstream read data valid |
| cfg_rdata | input | 32 | Downstream read data |
| resp_valid | output | 1 | Read completion pulse |
| resp_rdata | output | 32 | Read completion data |
| mabort_set | input | 1 | Sets received-master-abort status |
| tabort_set | input | 1 | Sets received-target-abort status |
| stat_mabort | output | 1 | Received-master-abort status bit |
| stat_tabort | output | 1 | Received-target-abort status bit |
| err_flag | output | 1 | Sticky empty-IDSEL error |

## Verification
The assertions assume that the downstream port raises `cfg_rvalid` only while a forwarded read is outstanding. They also assume that the CPU side holds a request only for a cycle in which `req_ready` is 1. The stimulus meets both assumptions. The driver waits for `req_ready` before it presents a request and removes the request one cycle later. The bench returns read data two cycles after it observes the forwarded read. The one stray `cfg_rvalid` is driven while the block is idle, and it tests only that the block ignores it.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int ADDR_W   = 32;
    localparam int BUS_W    = 8;
    localparam int DEV_W    = 5;
    localparam int FN_W     = 3;
    localparam int REG_W    = 6;
    localparam int SIZE_W   = 3;
    localparam int IDSEL_LO = 11;
    localparam int IDSEL_W  = ADDR_W - IDSEL_LO;
    localparam int TYPE1_BIT = 16;
    localparam int HALF_W   = ADDR_W / 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } xl_state_e;
endpackage

// File: rtl/cfgx_lowest_one.sv
module cfgx_lowest_one #(
    parameter int W   = 21,
    parameter int IDX_W = 5
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             none
);
    logic [W:0]   seen;
    logic [W-1:0] first;

    assign seen[0] = 1'b0;

    // first[i] marks the single set bit with nothing set below it
    for (genvar i = 0; i < W; i++) begin : g_scan
        assign first[i]  = vec[i] & ~seen[i];
        assign seen[i+1] = seen[i] | vec[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

    assign none = ~seen[W];
endmodule

// File: rtl/cfgx_addr_build.sv
module cfgx_addr_build
    import cfgx_pkg::*;
(
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] map_val,
    input  logic [BUS_W-1:0]  bus,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              no_dev,
    output logic              type1
);
    logic [ADDR_W-1:0]  joined;
    logic [DEV_W-1:0]   dev;
    logic [FN_W-1:0]    fn;
    logic [REG_W-1:0]   regn;
    logic [1:0]         lane;

    localparam int PAD_W = ADDR_W - 1 - BUS_W - DEV_W - FN_W - REG_W - 2;

    assign joined = {map_val[HALF_W-1:0], offset[HALF_W-1:0]};
    assign fn     = joined[IDSEL_LO-1 -: FN_W];
    assign regn   = joined[REG_W+1:2];
    assign lane   = joined[1:0];
    assign type1  = map_val[TYPE1_BIT];

    cfgx_lowest_one #(
        .W     (IDSEL_W),
        .IDX_W (DEV_W)
    ) u_dev (
        .vec  (joined[ADDR_W-1:IDSEL_LO]),
        .idx  (dev),
        .none (no_dev)
    );

    assign cyc_addr = {1'b1, {PAD_W{1'b0}}, bus, dev, fn, regn, lane};
endmodule

// File: rtl/cfgx_size_check.sv
module cfgx_size_check
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [SIZE_W-1:0] size,
    output logic              size_ok,
    output logic [DATA_W-1:0] lane_mask
);
    localparam int NBYTES = DATA_W / 8;

    logic [NBYTES-1:0] byte_en;

    always_comb begin
        size_ok = 1'b0;
        byte_en = '1;
        unique case (size)
            3'd1: begin size_ok = 1'b1; byte_en = NBYTES'(4'b0001); end
            3'd2: begin size_ok = 1'b1; byte_en = NBYTES'(4'b0011); end
            3'd4: begin size_ok = 1'b1; byte_en = NBYTES'(4'b1111); end
            default: begin size_ok = 1'b0; byte_en = '1; end
        endcase
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign lane_mask[b*8 +: 8] = {8{byte_en[b]}};
    end
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_offset,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [ADDR_W-1:0]   map_reg,
    input  logic [BUS_W-1:0]    bus_num,
    output logic                cfg_valid,
    output logic                cfg_write,
    output logic [ADDR_W-1:0]   cfg_addr,
    output logic [SIZE_W-1:0]   cfg_size,
    output logic [DATA_W-1:0]   cfg_wdata,
    input  logic                cfg_rvalid,
    input  logic [DATA_W-1:0]   cfg_rdata,
    output logic                resp_valid,
    output logic [DATA_W-1:0]   resp_rdata,
    input  logic                mabort_set,
    input  logic                tabort_set,
    output logic                stat_mabort,
    output logic                stat_tabort,
    output logic                err_flag
);
    typedef struct packed {
        xl_state_e          state;
        logic               cfg_valid;
        logic               cfg_write;
        logic [ADDR_W-1:0]  cfg_addr;
        logic [SIZE_W-1:0]  cfg_size;
        logic [DATA_W-1:0]  cfg_wdata;
        logic [DATA_W-1:0]  rd_mask;
        logic               resp_valid;
        logic [DATA_W-1:0]  resp_data;
        logic               mabort;
        logic               tabort;
        logic               err;
    } xl_regs_t;

    xl_regs_t r_d, r_q;

    logic [ADDR_W-1:0] built_addr;
    logic              no_dev;
    logic              type1;
    logic              size_ok;
    logic [DATA_W-1:0] lane_mask;
    logic              accept;
    logic              drop;

    cfgx_addr_build u_build (
        .offset   (req_offset),
        .map_val  (map_reg),
        .bus      (bus_num),
        .cyc_addr (built_addr),
        .no_dev   (no_dev),
        .type1    (type1)
    );

    cfgx_size_check #(
        .DATA_W (DATA_W)
    ) u_size (
        .size      (req_size),
        .size_ok   (size_ok),
        .lane_mask (lane_mask)
    );

    assign req_ready = (r_q.state == ST_IDLE);
    assign accept    = req_valid & req_ready;
    assign drop      = ~size_ok | type1 | no_dev;

    always_comb begin
        r_d            = r_q;
        r_d.cfg_valid  = 1'b0;
        r_d.resp_valid = 1'b0;

        if (mabort_set) r_d.mabort = 1'b1;
        if (tabort_set) r_d.tabort = 1'b1;

        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    // every accepted access clears both abort bits
                    r_d.mabort = 1'b0;
                    r_d.tabort = 1'b0;
                    if (drop) begin
                        if (size_ok && !type1 && no_dev) begin
                            r_d.err = 1'b1;
                        end
                        if (!req_write) begin
                            r_d.resp_valid = 1'b1;
                            r_d.resp_data  = lane_mask;
                        end
                    end else begin
                        r_d.cfg_valid = 1'b1;
                        r_d.cfg_write = req_write;
                        r_d.cfg_addr  = built_addr;
                        r_d.cfg_size  = req_size;
                        r_d.cfg_wdata = req_wdata;
                        if (!req_write) begin
                            r_d.rd_mask = lane_mask;
                            r_d.state   = ST_WAIT;
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (cfg_rvalid) begin
                    r_d.resp_valid = 1'b1;
                    r_d.resp_data  = cfg_rdata & r_q.rd_mask;
                    r_d.state      = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_valid   = r_q.cfg_valid;
    assign cfg_write   = r_q.cfg_write;
    assign cfg_addr    = r_q.cfg_addr;
    assign cfg_size    = r_q.cfg_size;
    assign cfg_wdata   = r_q.cfg_wdata;
    assign resp_valid  = r_q.resp_valid;
    assign resp_rdata  = r_q.resp_data;
    assign stat_mabort = r_q.mabort;
    assign stat_tabort = r_q.tabort;
    assign err_flag    = r_q.err;
endmodule

// File: rtl/cfg_addr_xlate_chk.sv
module cfg_addr_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [31:0] map_reg,
    input logic [2:0]  req_size,
    input logic        cfg_valid,
    input logic [31:0] cfg_addr,
    input logic [2:0]  cfg_size,
    input logic        cfg_rvalid,
    input logic        resp_valid,
    input logic        stat_mabort,
    input logic        stat_tabort,
    input logic        err_flag
);
    p_enable_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_addr[31] && cfg_addr[30:24] == 7'd0));

    p_dev_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_addr[15:11] <= 5'd20));

    p_type1_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && map_reg[16]) |=> !cfg_valid);

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_legal_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_size == 3'd1 || cfg_size == 3'd2 || cfg_size == 3'd4));

    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !cfg_rvalid) |=> (!req_ready && !resp_valid));

    p_rd_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && cfg_rvalid) |=> (resp_valid && req_ready));

    p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!stat_mabort && !stat_tabort));

    p_write_noresp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !resp_valid);

    p_bad_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4))
        |=> !cfg_valid);
endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .map_reg     (map_reg),
    .req_size    (req_size),
    .cfg_valid   (cfg_valid),
    .cfg_addr    (cfg_addr),
    .cfg_size    (cfg_size),
    .cfg_rvalid  (cfg_rvalid),
    .resp_valid  (resp_valid),
    .stat_mabort (stat_mabort),
    .stat_tabort (stat_tabort),
    .err_flag    (err_flag)
);

// File: tb/cfg_addr_xlate_test.sv
module cfg_addr_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_offset = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic [31:0] map_reg = '0;
    logic [7:0]  bus_num = '0;
    logic        cfg_valid, cfg_write;
    logic [31:0] cfg_addr, cfg_wdata;
    logic [2:0]  cfg_size;
    logic        cfg_rvalid = 1'b0;
    logic [31:0] cfg_rdata = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        mabort_set = 1'b0, tabort_set = 1'b0;
    logic        stat_mabort, stat_tabort, err_flag;

    localparam logic [31:0] RD_KEY = 32'hC3C3_0F0F;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] addr;
        logic        wr;
        logic [31:0] wdata;
        logic [2:0]  size;
        string       tag;
    } cfg_item_t;

    typedef struct {
        logic [31:0] data;
        string       tag;
    } resp_item_t;

    cfg_item_t  cfg_q[$];
    resp_item_t resp_q[$];

    always #2.5 clk = ~clk;

    cfg_addr_xlate uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_offset (req_offset), .req_size (req_size), .req_wdata (req_wdata),
        .map_reg (map_reg), .bus_num (bus_num),
        .cfg_valid (cfg_valid), .cfg_write (cfg_write), .cfg_addr (cfg_addr),
        .cfg_size (cfg_size), .cfg_wdata (cfg_wdata),
        .cfg_rvalid (cfg_rvalid), .cfg_rdata (cfg_rdata),
        .resp_valid (resp_valid), .resp_rdata (resp_rdata),
        .mabort_set (mabort_set), .tabort_set (tabort_set),
        .stat_mabort (stat_mabort), .stat_tabort (stat_tabort), .err_flag (err_flag)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] width_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // expected type-0 address built from the requirement text (R1, R2, R8)
    function automatic logic [31:0] model_addr(input logic [31:0] mp, input logic [31:0] of,
                                               input logic [7:0] bus, output bit empty);
        logic [31:0] j;
        logic [4:0]  dev;
        j = {mp[15:0], of[15:0]};
        dev = '0;
        empty = 1'b1;
        for (int i = 20; i >= 0; i--) begin
            if (j[11+i]) begin
                dev = 5'(i);
                empty = 1'b0;
            end
        end
        return {1'b1, 7'd0, bus, dev, j[10:8], j[7:2], j[1:0]};
    endfunction

    // driver: predicts, pushes expectations, drives one access, plays downstream
    task automatic access(input bit wr, input logic [31:0] of, input logic [2:0] sz,
                          input logic [31:0] wd, input logic [31:0] mp,
                          input logic [7:0] bus, input string tag);
        logic [31:0] ea;
        bit          empty, legal, fwd;
        cfg_item_t   ci;
        resp_item_t  ri;
        ea    = model_addr(mp, of, bus, empty);
        legal = (sz == 3'd1 || sz == 3'd2 || sz == 3'd4);
        fwd   = legal && !mp[16] && !empty;
        if (fwd) begin
            ci = '{addr: ea, wr: wr, wdata: wd, size: sz, tag: tag};
            cfg_q.push_back(ci);
        end
        if (!wr) begin
            ri.tag  = tag;
            ri.data = fwd ? ((ea ^ RD_KEY) & width_mask(sz)) : width_mask(sz);
            resp_q.push_back(ri);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_offset = of; req_size = sz;
        req_wdata = wd; map_reg = mp; bus_num = bus;
        @(negedge clk);
        req_valid = 1'b0;
        if (fwd && !wr) begin
            @(negedge clk);
            cfg_rvalid = 1'b1;
            cfg_rdata  = ea ^ RD_KEY;
            @(negedge clk);
            cfg_rvalid = 1'b0;
            cfg_rdata  = '0;
        end
        @(negedge clk);
    endtask

    // monitor: pops and compares as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cfg_valid) begin
                if (cfg_q.size() == 0) begin
                    check(1'b0, "R3/R4/R5 unexpected cfg_valid", cfg_addr, 32'h0);
                end else begin
                    cfg_item_t e;
                    e = cfg_q.pop_front();
                    check(cfg_addr == e.addr, {e.tag, " cfg_addr R1 R2 R8"}, cfg_addr, e.addr);
                    check(cfg_write == e.wr && cfg_size == e.size &&
                          (!e.wr || cfg_wdata == e.wdata),
                          {e.tag, " cfg fields R1"}, cfg_wdata, e.wdata);
                end
            end
            if (rst_n && resp_valid) begin
                if (resp_q.size() == 0) begin
                    check(1'b0, "R6/R10 unexpected resp_valid", resp_rdata, 32'h0);
                end else begin
                    resp_item_t r;
                    r = resp_q.pop_front();
                    check(resp_rdata == r.data, {r.tag, " resp data"}, resp_rdata, r.data);
                end
            end
        end
    end

    task automatic finish_run();
        check(cfg_q.size() == 0, "R1 cfg items left", 32'(cfg_q.size()), 32'h0);
        check(resp_q.size() == 0, "R6 resp items left", 32'(resp_q.size()), 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hang expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(req_ready && !cfg_valid && !resp_valid && !err_flag && !stat_mabort && !stat_tabort,
              "R9 reset state", {27'd0, req_ready, cfg_valid, resp_valid, err_flag, stat_mabort},
              32'h10);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 write: joined bit 17 -> device 6, function 3
        access(1'b1, 32'h0000_0304, 3'd4, 32'hDEAD_BEEF, 32'h0000_0002, 8'h00, "R1 wr dev6");
        // R2 device 0, R8 bus number
        access(1'b0, 32'h0000_0D10, 3'd4, '0, 32'h0000_0000, 8'h5A, "R2 R8 rd dev0");
        // R2 lowest bit wins among several, R6 2-byte mask
        access(1'b0, 32'h0000_F006, 3'd2, '0, 32'h0000_8041, 8'h01, "R2 multi idsel R6");
        // R2 top bit -> device 20, R6 1-byte mask, lane bits
        access(1'b0, 32'h0000_00FF, 3'd1, '0, 32'h0000_8000, 8'hFF, "R2 dev20 R6");
        // R1 back-to-back writes
        access(1'b1, 32'h0000_1008, 3'd2, 32'h0000_1234, 32'h0000_0010, 8'h03, "R1 wr a");
        access(1'b1, 32'h0000_200C, 3'd1, 32'h0000_0056, 32'h0000_0020, 8'h04, "R1 wr b");

        // R3 type-1 select drops writes and answers reads with ones
        access(1'b1, 32'h0000_0800, 3'd4, 32'h1111_1111, 32'h0001_0002, 8'h00, "R3 R10 wr drop");
        access(1'b0, 32'h0000_0800, 3'd1, '0, 32'h0001_0002, 8'h00, "R3 rd size1");
        access(1'b0, 32'h0000_0800, 3'd2, '0, 32'h0001_0000, 8'h00, "R3 rd size2");

        // R5 illegal size
        access(1'b0, 32'h0000_0800, 3'd3, '0, 32'h0000_0002, 8'h00, "R5 rd size3");
        access(1'b1, 32'h0000_0800, 3'd0, 32'h5, 32'h0000_0002, 8'h00, "R5 wr size0");
        check(!err_flag, "R5 err untouched", {31'd0, err_flag}, 32'h0);

        // R4 empty IDSEL
        access(1'b1, 32'h0000_0700, 3'd4, 32'h2, 32'h0000_0000, 8'h00, "R4 wr empty");
        check(err_flag, "R4 err set", {31'd0, err_flag}, 32'h1);
        access(1'b0, 32'h0000_0004, 3'd4, '0, 32'h0000_0000, 8'h00, "R4 rd empty");
        access(1'b0, 32'h0000_0800, 3'd4, '0, 32'h0000_0000, 8'h00, "R4 good rd");
        check(err_flag, "R4 err sticky", {31'd0, err_flag}, 32'h1);

        // R6 stray downstream data while idle is ignored (monitor flags any resp)
        @(negedge clk);
        cfg_rvalid = 1'b1; cfg_rdata = 32'hABCD_0123;
        @(negedge clk);
        cfg_rvalid = 1'b0;
        @(negedge clk);
        check(!resp_valid && req_ready, "R6 stray rvalid", {31'd0, resp_valid}, 32'h0);

        // R7 status bits set then cleared by an access
        mabort_set = 1'b1; tabort_set = 1'b1;
        @(negedge clk);
        mabort_set = 1'b0; tabort_set = 1'b0;
        @(negedge clk);
        check(stat_mabort && stat_tabort, "R7 set", {30'd0, stat_mabort, stat_tabort}, 32'h3);
        access(1'b1, 32'h0000_0800, 3'd4, 32'h7, 32'h0000_0000, 8'h00, "R7 wr clears");
        check(!stat_mabort && !stat_tabort, "R7 cleared", {30'd0, stat_mabort, stat_tabort}, 32'h0);

        // R7 clear wins over a set pulse in the accept cycle (dropped read)
        mabort_set = 1'b1;
        @(negedge clk);
        mabort_set = 1'b0;
        resp_q.push_back('{data: 32'hFFFF_FFFF, tag: "R7 rd clear-wins"});
        req_valid = 1'b1; req_write = 1'b0; req_offset = 32'h0800; req_size = 3'd4;
        map_reg = 32'h0001_0000; tabort_set = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; tabort_set = 1'b0;
        check(!stat_mabort && !stat_tabort, "R7 clear wins", {30'd0, stat_mabort, stat_tabort}, 32'h0);
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule